// File: doc/BRIEF.md
# Phase-Selectable SPI Slave

This block is a byte-wide SPI target that works under a faster system clock. It supports both SCK idle levels and both clock phases. The serial clock, select and data-in lines are brought into the system clock domain through two-flop synchronizers. Edges of SCK are then found by comparing consecutive synchronized samples, so the system clock must run at least four times faster than SCK.

A host sets the enable and mode bits through a small write port and presents the byte to send on `tx_byte`. Each completed frame raises `rx_done` for one system clock, with the received byte on `rx_byte`.

In the phase-0 format, the falling edge of select opens the frame and puts the transmit MSB on MISO at once. After 8 bits the block ignores further SCK edges until select is released and asserted again. In the phase-1 format, each bit goes out on the first edge of its SCK cycle. Bytes may follow one another under a single select.

Top module: `spi_slave_phased`

## Requirements
- R1: Bits on `mosi` are assembled MSB first. After the 8th sampling edge, `rx_byte` holds the 8 sampled bits, with the first bit in bit 7. This holds for all four combinations of polarity and phase.
- R2: `tx_byte` is sent on `miso` MSB first, one bit per SCK cycle. A master that samples on the sampling edge recovers `tx_byte` exactly.
- R3: `miso_oe` is high only while the block is enabled and select (`ss_n`) is low, after the synchronizer delay. It is low whenever select is high.
- R4: With phase 0 (`mode_cpha`=0), bit 7 of `tx_byte` is on `miso` as soon as `miso_oe` rises, before any SCK edge. The byte is loaded at the select falling edge.
- R5: With phase 0, once 8 bits have been received, further SCK edges under the same select produce no second `rx_done`. A new byte needs select to go high and then low again.
- R6: With phase 1, the next byte may follow under the same select. `tx_byte` is reloaded at the completion of each byte, and every byte raises its own `rx_done`.
- R7: Polarity 1 (SCK idle high) works like polarity 0 with the edge directions swapped. The leading edge is the falling one.
- R8: A configuration write always updates the enable bit. It updates the polarity and phase bits only if the block was disabled before that write. `mode_en`, `mode_cpol` and `mode_cpha` read back the stored bits.
- R9: `rx_done` is a single-cycle pulse, raised only while select is low.
- R10: If select rises before 8 bits have been sampled, the partial frame is dropped with no `rx_done`. The next frame starts from bit 7.
- R11: While disabled, the block drives no `miso_oe` and raises no `rx_done`, whatever happens on the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Enable value to write |
| cfg_cpol | input | 1 | SCK idle level to write |
| cfg_cpha | input | 1 | Clock phase to write |
| mode_en | output | 1 | Stored enable bit |
| mode_cpol | output | 1 | Stored polarity bit |
| mode_cpha | output | 1 | Stored phase bit |
| tx_byte | input | W | Byte to send in the next frame |
| rx_byte | output | W | Last complete received byte |
| rx_done | output | 1 | One-cycle pulse when a byte completes |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| ss_n | input | 1 | Active-low select |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for `miso` |

## Verification
Some rules can be checked on every cycle against the ports and the stored mode bits:
- the output enable follows select, with a fixed latency;
- the done pulse lasts one cycle, needs select low and needs the block enabled;
- the mode bits stay frozen while enabled;
- in phase 0, the MSB is present at the rising of the output enable.

Other behaviours only show up in the bench's frame scenarios:
- byte order in both directions;
- the ignored extra clocks after a phase-0 byte;
- back-to-back phase-1 bytes;
- dropping of aborted frames;
- both polarities.

// File: rtl/spi_slave_phased.sv
module spi_slave_phased #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_wr,
  input  logic         cfg_en,
  input  logic         cfg_cpol,
  input  logic         cfg_cpha,
  output logic         mode_en,
  output logic         mode_cpol,
  output logic         mode_cpha,
  input  logic [W-1:0] tx_byte,
  output logic [W-1:0] rx_byte,
  output logic         rx_done,
  input  logic         sck,
  input  logic         mosi,
  input  logic         ss_n,
  output logic         miso,
  output logic         miso_oe
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [2:0]   sck_s;
  logic [1:0]   mosi_s;
  logic [1:0]   ss_s;
  logic [CW-1:0] cnt;
  logic         hold;
  logic         miso_q;
  logic [W-1:0] tx_sh;
  logic [W-2:0] rx_sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_en   <= 1'b0;
      mode_cpol <= 1'b0;
      mode_cpha <= 1'b0;
    end else if (cfg_wr) begin
      mode_en <= cfg_en;
      if (!mode_en) begin
        mode_cpol <= cfg_cpol;
        mode_cpha <= cfg_cpha;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s  <= '0;
      mosi_s <= '0;
      ss_s   <= '1;
    end else begin
      sck_s  <= {sck_s[1:0], sck};
      mosi_s <= {mosi_s[0], mosi};
      ss_s   <= {ss_s[0], ss_n};
    end

  wire rise      = sck_s[1] & ~sck_s[2];
  wire fall      = ~sck_s[1] & sck_s[2];
  wire lead      = mode_cpol ? fall : rise;
  wire trail     = mode_cpol ? rise : fall;
  wire samp      = mode_cpha ? trail : lead;
  wire shft      = mode_cpha ? lead : trail;
  wire sel_start = ss_s[1] & ~ss_s[0];
  wire sel_end   = ~ss_s[1] & ss_s[0];
  wire active    = mode_en & ~ss_s[1];
  wire [W-1:0] rx_next = {rx_sh, mosi_s[1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt     <= '0;
      hold    <= 1'b0;
      miso_q  <= 1'b0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_byte <= '0;
      rx_done <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (!mode_en || sel_end) begin
        cnt  <= '0;
        hold <= 1'b0;
      end else if (sel_start) begin
        cnt  <= '0;
        hold <= 1'b0;
        if (!mode_cpha) begin
          miso_q <= tx_byte[W-1];
          tx_sh  <= tx_byte << 1;
        end else begin
          miso_q <= 1'b0;
          tx_sh  <= tx_byte;
        end
      end else if (active && !hold) begin
        if (shft) begin
          miso_q <= tx_sh[W-1];
          tx_sh  <= tx_sh << 1;
        end
        if (samp) begin
          rx_sh <= rx_next[W-2:0];
          cnt   <= cnt + 1'b1;
          if (cnt == LAST) begin
            rx_byte <= rx_next;
            rx_done <= 1'b1;
            cnt     <= '0;
            if (!mode_cpha) hold <= 1'b1;
            else            tx_sh <= tx_byte;
          end
        end
      end
    end

  assign miso    = miso_q;
  assign miso_oe = active;
endmodule

module spi_slave_phased_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ss_n,
  input logic [W-1:0] tx_byte,
  input logic         miso,
  input logic         miso_oe,
  input logic         rx_done,
  input logic         mode_en,
  input logic         mode_cpol,
  input logic         mode_cpha
);
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);
  // R9
  done_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> !$past(ss_n, 3));
  // R3
  oe_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> !$past(ss_n, 2));
  // R8
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_en) |-> $stable(mode_cpol) && $stable(mode_cpha));
  // R11
  dis_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mode_en) |-> !rx_done);
  // R4
  msb_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe) && !mode_cpha && $past(mode_en) |-> miso == $past(tx_byte[W-1]));
endmodule

bind spi_slave_phased spi_slave_phased_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .tx_byte(tx_byte), .miso(miso),
  .miso_oe(miso_oe), .rx_done(rx_done), .mode_en(mode_en),
  .mode_cpol(mode_cpol), .mode_cpha(mode_cpha)
);

// File: tb/tb_spi_slave_phased.sv
module tb_spi_slave_phased;
  localparam int CLK_PERIOD = 10;
  localparam int H = 5;

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, cfg_en = 0, cfg_cpol = 0, cfg_cpha = 0;
  logic mode_en, mode_cpol, mode_cpha;
  logic [7:0] tx_byte = 0, rx_byte;
  logic rx_done, miso, miso_oe;
  logic sck = 0, mosi = 0, ss_n = 1;
  logic cur_cpol = 0, cur_cpha = 0;

  int checks = 0, errors = 0, done_cnt = 0;
  logic [7:0] last_rx = 0;

  spi_slave_phased #(.W(8)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rx_done) begin done_cnt++; last_rx = rx_byte; end

  function automatic logic idle_level(input logic pol); return pol; endfunction
  function automatic logic [7:0] expect_rx(input logic [7:0] m, input int n, input logic [7:0] prev);
    return (n == 8) ? m : prev;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic e, input logic p, input logic h);
    @(negedge clk); cfg_wr = 1; cfg_en = e; cfg_cpol = p; cfg_cpha = h;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic configure(input logic p, input logic h);
    cfg_write(0, p, h);
    cfg_write(0, p, h);
    sck = idle_level(p); cur_cpol = p; cur_cpha = h;
    repeat (4) @(negedge clk);
    cfg_write(1, p, h);
  endtask

  task automatic sel_low;
    @(negedge clk); ss_n = 0; repeat (H) @(negedge clk);
  endtask

  task automatic sel_high;
    repeat (H) @(negedge clk); ss_n = 1; repeat (2*H) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [7:0] mo, input int n, output logic [7:0] mi);
    mi = 0;
    for (int i = 0; i < n; i++) begin
      if (!cur_cpha) begin
        mosi = mo[7-i]; repeat (H) @(negedge clk);
        sck = ~cur_cpol; mi[7-i] = miso; repeat (H) @(negedge clk);
        sck = cur_cpol;
      end else begin
        sck = ~cur_cpol; mosi = mo[7-i]; repeat (H) @(negedge clk);
        sck = cur_cpol; mi[7-i] = miso; repeat (H) @(negedge clk);
      end
    end
  endtask

  task automatic full_frame(input string tag, input logic [7:0] mo, input logic [7:0] tx);
    logic [7:0] mi; int d0;
    tx_byte = tx; d0 = done_cnt;
    sel_low;
    chk({tag, " R3 oe while selected"}, miso_oe, 1);
    if (!cur_cpha) chk({tag, " R4 msb before first edge"}, miso, tx[7]);
    shift_bits(mo, 8, mi);
    sel_high;
    chk({tag, " R9 one done"}, done_cnt, d0 + 1);
    chk({tag, " R1 rx byte"}, last_rx, expect_rx(mo, 8, last_rx));
    chk({tag, " R2 miso byte"}, mi, tx);
    chk({tag, " R3 oe released"}, miso_oe, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] mi, mi2, r1; int d0;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R3 reset oe", miso_oe, 0);
    chk("R9 reset done", rx_done, 0);
    chk("R8 reset enable", mode_en, 0);

    for (int k = 0; k < 16; k++) begin
      logic p, h;
      p = 1'($urandom); h = 1'($urandom);
      configure(p, h);
      full_frame(p ? "R7 rand" : "rand", 8'($urandom), 8'($urandom));
    end

    configure(1, 0); full_frame("R7 pol1 ph0", 8'hA5, 8'h3C);
    configure(1, 1); full_frame("R7 pol1 ph1", 8'h81, 8'h7E);
    configure(0, 0); full_frame("ph0 edge", 8'h00, 8'hFF);

    // R5: extra clocks after a phase-0 byte under one select
    configure(0, 0);
    tx_byte = 8'hC3; d0 = done_cnt;
    sel_low;
    shift_bits(8'h5A, 8, mi);
    shift_bits(8'h96, 8, mi2);
    repeat (H) @(negedge clk);
    chk("R5 no second done", done_cnt, d0 + 1);
    chk("R5 first byte kept", last_rx, 8'h5A);
    sel_high;
    full_frame("R5 after toggle", 8'h69, 8'h17);

    // R6: two phase-1 bytes under one select
    configure(0, 1);
    tx_byte = 8'hE1; d0 = done_cnt;
    sel_low;
    tx_byte = 8'h2D;
    shift_bits(8'h33, 8, mi);
    r1 = last_rx;
    shift_bits(8'hCC, 8, mi2);
    sel_high;
    chk("R6 two dones", done_cnt, d0 + 2);
    chk("R6 first rx", r1, 8'h33);
    chk("R6 second rx", last_rx, 8'hCC);
    chk("R6 first tx", mi, 8'hE1);
    chk("R6 second tx reloaded", mi2, 8'h2D);

    // R10: aborted frames in both phases
    for (int ph = 0; ph < 2; ph++) begin
      configure(0, 1'(ph));
      tx_byte = 8'h55; d0 = done_cnt;
      sel_low; shift_bits(8'hF0, 5, mi); sel_high;
      chk("R10 abort no done", done_cnt, d0);
      full_frame("R10 clean restart", 8'h4B, 8'hB4);
    end

    // R8: mode writes while enabled are ignored
    configure(0, 0);
    cfg_write(1, 1, 1);
    chk("R8 cpol frozen", mode_cpol, 0);
    chk("R8 cpha frozen", mode_cpha, 0);
    cfg_write(0, 1, 1);
    chk("R8 disabling write keeps mode", {mode_en, mode_cpol, mode_cpha}, 3'b000);
    cfg_write(0, 1, 1);
    chk("R8 write while disabled", {mode_en, mode_cpol, mode_cpha}, 3'b011);

    // R11: disabled block stays silent
    cur_cpol = 1; cur_cpha = 1; sck = 1;
    d0 = done_cnt;
    sel_low;
    chk("R11 no oe when disabled", miso_oe, 0);
    shift_bits(8'hAA, 8, mi);
    sel_high;
    chk("R11 no done when disabled", done_cnt, d0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule